// File: doc/BRIEF.md
# Signed 128-bit Remainder Unit

This is a multi-cycle execution unit that takes two 128-bit two's-complement operands and returns the remainder of their signed division. The quotient is truncated toward zero. Only the remainder leaves the unit. The unit takes the absolute value of each operand and runs a restoring shift-subtract loop that retires one dividend bit per clock. A final cycle then applies the dividend's sign to the remainder magnitude.

A request is a one-cycle pulse on `req_valid` while the unit is idle. The unit samples the `fac_en` input with the request. When `fac_en` is low, the unit computes nothing and answers at once with a facility fault. Two operand pairs give no usable result: a zero divisor, and the most negative value divided by minus one. The unit detects both in its setup cycle and answers each with its own fault flag and a zero result. It does not run the loop for them.

All results appear on a one-cycle `rsp_valid` pulse. While a computation is in progress, the unit holds `busy` high and ignores new requests.

Top module: `sdiv_remainder_unit`

## Requirements
- R1: For a non-faulting request, `rem_out` equals the 128-bit signed value dividend − q×divisor, where q is dividend/divisor truncated toward zero.
- R2: When the dividend is nonnegative, the result satisfies 0 ≤ r < |divisor|. When the dividend is negative, the result satisfies −|divisor| < r ≤ 0. The sign of the divisor never changes the result.
- R3: A dividend of 0x8000…0 (only bit 127 set) with a divisor of all ones (−1) raises `fault_ovf` together with `rsp_valid`, and drives `rem_out` to zero.
- R4: A zero divisor raises `fault_div0` together with `rsp_valid` and drives `rem_out` to zero. The unit does not hang, and it returns to idle.
- R5: A request made while `fac_en` is 0 raises `fault_unavail` with `rsp_valid` on the first clock after the accepting edge. `rem_out` is driven to zero and `busy` stays low. This fault takes precedence over the operand faults.
- R6: Latency is counted in rising edges, starting with the accepting edge as edge 1. A non-faulting request gives `rsp_valid` after edge WIDTH+3 (131 for the default width). The R3 and R4 cases answer after edge 2. `rsp_valid` is high for exactly one cycle.
- R7: `busy` is high from the cycle after acceptance until the response cycle. A request made while `busy` is high is ignored: it produces no extra response and does not change the result in flight.
- R8: A synchronous active-high reset returns the unit to idle. It clears `busy`, `rsp_valid`, all fault flags and `rem_out`, and it abandons any operation in progress.
- R9: At most one fault flag is high at any time, and a fault flag is high only together with `rsp_valid`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| req_valid | input | 1 | Request pulse; accepted only while idle |
| fac_en | input | 1 | Facility enable, sampled with the request |
| dividend | input | WIDTH | Signed dividend |
| divisor | input | WIDTH | Signed divisor |
| busy | output | 1 | A computation is in progress |
| rsp_valid | output | 1 | One-cycle response strobe |
| rem_out | output | WIDTH | Signed remainder; zero on any fault |
| fault_unavail | output | 1 | Request refused because the facility is disabled |
| fault_div0 | output | 1 | Divisor was zero |
| fault_ovf | output | 1 | Most-negative dividend with divisor −1 |

## Verification
The bench runs every combination of operand signs. A design that takes the remainder's sign from the divisor, or that uses floored modulo, returns a wrong sign or an offset by |divisor| for the mixed-sign vectors. The bench also uses the most negative value as dividend and as divisor, and uses the largest positive dividend against a divisor of magnitude 2^127. These cases break a design whose absolute-value logic overflows or whose partial remainder is one bit too narrow.

For the zero-divisor, overflow-pair and disabled-facility cases, the bench checks the result, the flag and the latency. A unit that runs the loop anyway, sets the wrong flag, or ranks the operand faults above the facility fault is caught. A stray request sent mid-run and a reset sent mid-run show whether the unit restarts on its own or lets a response escape.

// File: rtl/srem_pkg.sv
package srem_pkg;

   typedef enum logic [1:0] {
      ST_IDLE  = 2'd0,
      ST_SETUP = 2'd1,
      ST_RUN   = 2'd2,
      ST_FIX   = 2'd3
   } srem_state_e;

   typedef struct packed {
      logic unavail;
      logic div0;
      logic ovf;
   } srem_fault_t;

   // implementation choices for two's-complement negation
   localparam int NEG_MUX = 0;   // select between value and its negation
   localparam int NEG_XOR = 1;   // conditional invert plus carry-in

endpackage

// File: rtl/srem_operand_prep.sv
module srem_operand_prep #(
   parameter int WIDTH     = 128,
   parameter int NEG_STYLE = srem_pkg::NEG_MUX
) (
   input  logic [WIDTH-1:0] dvd_i,
   input  logic [WIDTH-1:0] dvs_i,
   output logic [WIDTH-1:0] dvd_mag_o,
   output logic [WIDTH-1:0] dvs_mag_o,
   output logic             dvd_neg_o,
   output logic             div0_o,
   output logic             ovf_o
);
   localparam logic [WIDTH-1:0] MOST_NEG  = {1'b1, {(WIDTH-1){1'b0}}};
   localparam logic [WIDTH-1:0] MINUS_ONE = {WIDTH{1'b1}};
   localparam int               N_OPS     = 2;

   initial begin
      a_width_ok: assert (WIDTH >= 4) else $error("WIDTH must be at least 4");
      a_style_ok: assert (NEG_STYLE == srem_pkg::NEG_MUX || NEG_STYLE == srem_pkg::NEG_XOR)
         else $error("unknown NEG_STYLE");
   end

   logic [WIDTH-1:0] raw [N_OPS];
   logic [WIDTH-1:0] mag [N_OPS];

   assign raw[0] = dvd_i;
   assign raw[1] = dvs_i;

   for (genvar g = 0; g < N_OPS; g++) begin : g_abs
      if (NEG_STYLE == srem_pkg::NEG_XOR) begin : g_xor
         assign mag[g] = (raw[g] ^ {WIDTH{raw[g][WIDTH-1]}}) + WIDTH'(raw[g][WIDTH-1]);
      end else begin : g_mux
         assign mag[g] = raw[g][WIDTH-1] ? (~raw[g] + 1'b1) : raw[g];
      end

      // magnitude top bit is set only for the most negative operand (R1)
      always_comb begin
         p_mag_range_r1: assert (!mag[g][WIDTH-1] || raw[g] == MOST_NEG);
      end
   end

   assign dvd_mag_o = mag[0];
   assign dvs_mag_o = mag[1];
   assign dvd_neg_o = dvd_i[WIDTH-1];
   assign div0_o    = (dvs_i == '0);
   assign ovf_o     = (dvd_i == MOST_NEG) && (dvs_i == MINUS_ONE);

endmodule

// File: rtl/srem_restoring_core.sv
module srem_restoring_core #(
   parameter int WIDTH = 128
) (
   input  logic             clk,
   input  logic             rst,
   input  logic             load_i,
   input  logic             step_i,
   input  logic [WIDTH-1:0] dvd_mag_i,
   input  logic [WIDTH-1:0] dvs_mag_i,
   output logic [WIDTH-1:0] rem_mag_o,
   output logic             last_o
);
   localparam int               CNT_W    = (WIDTH > 1) ? $clog2(WIDTH) : 1;
   localparam logic [CNT_W-1:0] LAST_IDX = CNT_W'(WIDTH - 1);

   logic [WIDTH-1:0] rem_q;
   logic [WIDTH-1:0] shf_q;
   logic [WIDTH-1:0] dvs_q;
   logic [CNT_W-1:0] cnt_q;
   logic             active_q;
   logic [WIDTH:0]   trial;

   // partial remainder shifted left with the next dividend bit, minus divisor
   assign trial = {rem_q, shf_q[WIDTH-1]} - {1'b0, dvs_q};

   always_ff @(posedge clk) begin
      if (rst) begin
         rem_q    <= '0;
         shf_q    <= '0;
         dvs_q    <= '0;
         cnt_q    <= '0;
         active_q <= 1'b0;
      end else if (load_i) begin
         rem_q    <= '0;
         shf_q    <= dvd_mag_i;
         dvs_q    <= dvs_mag_i;
         cnt_q    <= '0;
         active_q <= 1'b1;
      end else if (step_i) begin
         rem_q <= trial[WIDTH] ? {rem_q[WIDTH-2:0], shf_q[WIDTH-1]} : trial[WIDTH-1:0];
         shf_q <= {shf_q[WIDTH-2:0], 1'b0};
         cnt_q <= cnt_q + 1'b1;
      end
   end

   assign rem_mag_o = rem_q;
   assign last_o    = step_i && (cnt_q == LAST_IDX);

   // partial remainder stays below the divisor magnitude (R2)
   p_rem_bound_r2: assert property (@(posedge clk) disable iff (rst)
      active_q |-> (rem_q < dvs_q));

   // iterations only run on loaded operands (R6)
   p_step_loaded_r6: assert property (@(posedge clk) disable iff (rst)
      step_i |-> active_q);

endmodule

// File: rtl/srem_sign_fix.sv
module srem_sign_fix #(
   parameter int WIDTH     = 128,
   parameter int NEG_STYLE = srem_pkg::NEG_MUX
) (
   input  logic [WIDTH-1:0] mag_i,
   input  logic             neg_i,
   output logic [WIDTH-1:0] val_o
);
   if (NEG_STYLE == srem_pkg::NEG_XOR) begin : g_xor
      assign val_o = (mag_i ^ {WIDTH{neg_i}}) + WIDTH'(neg_i);
   end else begin : g_mux
      assign val_o = neg_i ? (~mag_i + 1'b1) : mag_i;
   end

   // a negated nonzero magnitude below 2^(WIDTH-1) must come out negative (R2)
   always_comb begin
      p_neg_sign_r2: assert (!(neg_i && mag_i != '0 && !mag_i[WIDTH-1]) || val_o[WIDTH-1]);
   end

endmodule

// File: rtl/sdiv_remainder_unit.sv
module sdiv_remainder_unit
   import srem_pkg::*;
#(
   parameter int WIDTH     = 128,
   parameter int NEG_STYLE = NEG_MUX
) (
   input  logic             clk,
   input  logic             rst,
   input  logic             req_valid,
   input  logic             fac_en,
   input  logic [WIDTH-1:0] dividend,
   input  logic [WIDTH-1:0] divisor,
   output logic             busy,
   output logic             rsp_valid,
   output logic [WIDTH-1:0] rem_out,
   output logic             fault_unavail,
   output logic             fault_div0,
   output logic             fault_ovf
);
   srem_state_e      state_q;
   logic [WIDTH-1:0] a_q;
   logic [WIDTH-1:0] b_q;
   logic             neg_q;
   logic             rsp_q;
   logic [WIDTH-1:0] rem_q;
   srem_fault_t      flt_q;

   logic [WIDTH-1:0] dvd_mag;
   logic [WIDTH-1:0] dvs_mag;
   logic             dvd_neg;
   logic             pre_div0;
   logic             pre_ovf;
   logic             core_load;
   logic             core_step;
   logic             core_last;
   logic [WIDTH-1:0] core_rem;
   logic [WIDTH-1:0] fixed_rem;

   srem_operand_prep #(.WIDTH(WIDTH), .NEG_STYLE(NEG_STYLE)) u_prep (
      .dvd_i     (a_q),
      .dvs_i     (b_q),
      .dvd_mag_o (dvd_mag),
      .dvs_mag_o (dvs_mag),
      .dvd_neg_o (dvd_neg),
      .div0_o    (pre_div0),
      .ovf_o     (pre_ovf)
   );

   assign core_load = (state_q == ST_SETUP) && !pre_div0 && !pre_ovf;
   assign core_step = (state_q == ST_RUN);

   srem_restoring_core #(.WIDTH(WIDTH)) u_core (
      .clk       (clk),
      .rst       (rst),
      .load_i    (core_load),
      .step_i    (core_step),
      .dvd_mag_i (dvd_mag),
      .dvs_mag_i (dvs_mag),
      .rem_mag_o (core_rem),
      .last_o    (core_last)
   );

   srem_sign_fix #(.WIDTH(WIDTH), .NEG_STYLE(NEG_STYLE)) u_fix (
      .mag_i (core_rem),
      .neg_i (neg_q),
      .val_o (fixed_rem)
   );

   always_ff @(posedge clk) begin
      if (rst) begin
         state_q <= ST_IDLE;
         a_q     <= '0;
         b_q     <= '0;
         neg_q   <= 1'b0;
         rsp_q   <= 1'b0;
         rem_q   <= '0;
         flt_q   <= '0;
      end else begin
         rsp_q <= 1'b0;
         flt_q <= '0;
         case (state_q)
            ST_IDLE: begin
               if (req_valid) begin
                  if (!fac_en) begin
                     rsp_q         <= 1'b1;
                     flt_q.unavail <= 1'b1;
                     rem_q         <= '0;
                  end else begin
                     a_q     <= dividend;
                     b_q     <= divisor;
                     state_q <= ST_SETUP;
                  end
               end
            end
            ST_SETUP: begin
               if (pre_div0) begin
                  rsp_q      <= 1'b1;
                  flt_q.div0 <= 1'b1;
                  rem_q      <= '0;
                  state_q    <= ST_IDLE;
               end else if (pre_ovf) begin
                  rsp_q     <= 1'b1;
                  flt_q.ovf <= 1'b1;
                  rem_q     <= '0;
                  state_q   <= ST_IDLE;
               end else begin
                  neg_q   <= dvd_neg;
                  state_q <= ST_RUN;
               end
            end
            ST_RUN: begin
               if (core_last) state_q <= ST_FIX;
            end
            ST_FIX: begin
               rem_q   <= fixed_rem;
               rsp_q   <= 1'b1;
               state_q <= ST_IDLE;
            end
            default: state_q <= ST_IDLE;
         endcase
      end
   end

   assign busy          = (state_q != ST_IDLE);
   assign rsp_valid     = rsp_q;
   assign rem_out       = rem_q;
   assign fault_unavail = flt_q.unavail;
   assign fault_div0    = flt_q.div0;
   assign fault_ovf     = flt_q.ovf;

   p_one_fault_r9: assert property (@(posedge clk) disable iff (rst)
      $onehot0({fault_unavail, fault_div0, fault_ovf}));

   p_fault_with_rsp_r9: assert property (@(posedge clk) disable iff (rst)
      (fault_unavail || fault_div0 || fault_ovf) |-> rsp_valid);

   p_fault_zero_r4: assert property (@(posedge clk) disable iff (rst)
      (rsp_valid && (fault_unavail || fault_div0 || fault_ovf)) |-> (rem_out == '0));

   p_sign_dividend_r2: assert property (@(posedge clk) disable iff (rst)
      (rsp_valid && !(fault_unavail || fault_div0 || fault_ovf))
         |-> (neg_q ? (rem_out[WIDTH-1] || rem_out == '0) : !rem_out[WIDTH-1]));

   p_rsp_idle_r7: assert property (@(posedge clk) disable iff (rst)
      rsp_valid |-> !busy);

   p_busy_ignores_r7: assert property (@(posedge clk) disable iff (rst)
      (busy && req_valid) |=> ($stable(a_q) && $stable(b_q)));

   p_unavail_no_busy_r5: assert property (@(posedge clk) disable iff (rst)
      fault_unavail |-> !busy);

endmodule

// File: tb/sdiv_remainder_unit_bench.sv
`timescale 1ns/1ps
module sdiv_remainder_unit_bench;
   localparam int W      = 128;
   localparam int LAT_OK = W + 3;
   localparam int LAT_SP = 2;
   localparam logic [W-1:0] MINV = {1'b1, {(W-1){1'b0}}};
   localparam logic [W-1:0] MAXV = {1'b0, {(W-1){1'b1}}};

   // flag code: {unavail, div0, ovf}
   typedef struct packed {
      logic [W-1:0] a;
      logic [W-1:0] b;
      logic [W-1:0] r;
      logic [2:0]   f;
   } vec_t;

   localparam int NV = 18;
   localparam vec_t VECS [NV] = '{
      '{ 128'sd7,  128'sd3,  128'sd1,  3'b000},
      '{-128'sd7,  128'sd3, -128'sd1,  3'b000},
      '{ 128'sd7, -128'sd3,  128'sd1,  3'b000},
      '{-128'sd7, -128'sd3, -128'sd1,  3'b000},
      '{ 128'sd6,  128'sd3,  128'sd0,  3'b000},
      '{ 128'sd0,  128'sd5,  128'sd0,  3'b000},
      '{ 128'sd5,  128'sd7,  128'sd5,  3'b000},
      '{-128'sd5,  128'sd7, -128'sd5,  3'b000},
      '{ MINV,     128'sd3, -128'sd2,  3'b000},
      '{ MINV,     MINV,     128'sd0,  3'b000},
      '{ MAXV,     MINV,     MAXV,     3'b000},
      '{ MAXV,     128'h1_0000_0000_0000_0000, 128'hFFFF_FFFF_FFFF_FFFF, 3'b000},
      '{-128'sd1,  128'sd1,  128'sd0,  3'b000},
      '{ MINV,     128'sd1,  128'sd0,  3'b000},
      '{ MINV,    -128'sd1,  128'sd0,  3'b001},
      '{ 128'sd5,  128'sd0,  128'sd0,  3'b010},
      '{ MINV,     128'sd0,  128'sd0,  3'b010},
      '{ 128'sd0,  128'sd0,  128'sd0,  3'b010}
   };

   logic         clk = 1'b0;
   logic         rst = 1'b1;
   logic         req_valid = 1'b0;
   logic         fac_en = 1'b1;
   logic [W-1:0] dividend = '0;
   logic [W-1:0] divisor = '0;
   logic         busy;
   logic         rsp_valid;
   logic [W-1:0] rem_out;
   logic         fault_unavail;
   logic         fault_div0;
   logic         fault_ovf;

   int n_checks = 0;
   int n_fail   = 0;

   always #2.5 clk = ~clk;

   sdiv_remainder_unit #(.WIDTH(W)) u_sdiv_remainder_unit (
      .clk           (clk),
      .rst           (rst),
      .req_valid     (req_valid),
      .fac_en        (fac_en),
      .dividend      (dividend),
      .divisor       (divisor),
      .busy          (busy),
      .rsp_valid     (rsp_valid),
      .rem_out       (rem_out),
      .fault_unavail (fault_unavail),
      .fault_div0    (fault_div0),
      .fault_ovf     (fault_ovf)
   );

   task automatic check(input bit ok, input string req, input logic [W-1:0] act,
                        input logic [W-1:0] exp);
      n_checks++;
      if (!ok) begin
         n_fail++;
         $display("FAIL %s actual=%h expected=%h", req, act, exp);
      end
   endtask

   // issue one request; returns result, flags and latency in rising edges
   task automatic run_op(input logic [W-1:0] a, input logic [W-1:0] b, input logic en,
                         output logic [W-1:0] r, output logic [2:0] f, output int lat,
                         output logic pulse_ok);
      @(negedge clk);
      dividend  = a;
      divisor   = b;
      fac_en    = en;
      req_valid = 1'b1;
      @(posedge clk);
      lat = 1;
      @(negedge clk);
      req_valid = 1'b0;
      while (!rsp_valid && lat < 400) begin
         @(posedge clk);
         lat++;
         @(negedge clk);
      end
      r = rem_out;
      f = {fault_unavail, fault_div0, fault_ovf};
      @(posedge clk);
      @(negedge clk);
      pulse_ok = !rsp_valid;
   endtask

   initial begin
      repeat (150000) @(posedge clk);
      n_checks++;
      n_fail++;
      $display("FAIL watchdog expired");
      $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
      $finish;
   end

   initial begin
      logic [W-1:0] r;
      logic [2:0]   f;
      int           lat;
      logic         pok;
      int           extra;

      repeat (3) @(posedge clk);
      @(negedge clk);
      // R8: reset state
      check(busy == 1'b0 && rsp_valid == 1'b0, "R8 reset busy/rsp",
            W'({busy, rsp_valid}), '0);
      check({fault_unavail, fault_div0, fault_ovf} == 3'b000, "R8 reset flags",
            W'({fault_unavail, fault_div0, fault_ovf}), '0);
      check(rem_out == '0, "R8 reset rem_out", rem_out, '0);
      rst = 1'b0;

      // R1 R2 R3 R4 R6: table walk
      for (int i = 0; i < NV; i++) begin
         run_op(VECS[i].a, VECS[i].b, 1'b1, r, f, lat, pok);
         check(r == VECS[i].r, $sformatf("R1/R2 vec %0d remainder", i), r, VECS[i].r);
         check(f == VECS[i].f, $sformatf("R3/R4 vec %0d flags", i), W'(f), W'(VECS[i].f));
         check(lat == ((VECS[i].f == 3'b000) ? LAT_OK : LAT_SP),
               $sformatf("R6 vec %0d latency", i), W'(lat),
               W'((VECS[i].f == 3'b000) ? LAT_OK : LAT_SP));
         check(pok, $sformatf("R6 vec %0d one-cycle strobe", i), W'(!pok), '0);
      end

      // R5: facility disabled, ordinary operands
      run_op(128'sd7, 128'sd3, 1'b0, r, f, lat, pok);
      check(f == 3'b100, "R5 unavail flag", W'(f), W'(3'b100));
      check(r == '0, "R5 unavail result zero", r, '0);
      check(lat == 1, "R5 unavail latency", W'(lat), W'(1));
      check(pok, "R5 unavail strobe width", W'(!pok), '0);
      check(!busy, "R5 busy stays low", W'(busy), '0);

      // R5: facility fault outranks divide-by-zero
      run_op(128'sd9, 128'sd0, 1'b0, r, f, lat, pok);
      check(f == 3'b100, "R5 precedence over div0", W'(f), W'(3'b100));

      // R7: request while busy is ignored
      @(negedge clk);
      dividend = 128'sd100; divisor = 128'sd7; fac_en = 1'b1; req_valid = 1'b1;
      @(posedge clk);
      lat = 1;
      @(negedge clk);
      req_valid = 1'b0;
      repeat (10) begin @(posedge clk); lat++; @(negedge clk); end
      check(busy, "R7 busy during run", W'(busy), W'(1));
      dividend = 128'sd55; divisor = 128'sd4; req_valid = 1'b1;
      @(posedge clk); lat++;
      @(negedge clk);
      req_valid = 1'b0;
      while (!rsp_valid && lat < 400) begin @(posedge clk); lat++; @(negedge clk); end
      check(rem_out == 128'sd2, "R7 in-flight result kept", rem_out, 128'sd2);
      check(lat == LAT_OK, "R7 latency unchanged", W'(lat), W'(LAT_OK));
      extra = 0;
      repeat (W + 10) begin @(posedge clk); @(negedge clk); if (rsp_valid) extra++; end
      check(extra == 0, "R7 no extra response", W'(extra), '0);

      // R8: reset mid-run abandons the operation
      @(negedge clk);
      dividend = 128'sd11; divisor = 128'sd4; req_valid = 1'b1;
      @(posedge clk);
      @(negedge clk);
      req_valid = 1'b0;
      repeat (20) begin @(posedge clk); @(negedge clk); end
      rst = 1'b1;
      @(posedge clk);
      @(negedge clk);
      rst = 1'b0;
      check(!busy, "R8 mid-run reset clears busy", W'(busy), '0);
      extra = 0;
      repeat (W + 10) begin @(posedge clk); @(negedge clk); if (rsp_valid) extra++; end
      check(extra == 0, "R8 no response after reset", W'(extra), '0);

      // R1 after reset: unit still usable
      run_op(-128'sd23, 128'sd5, 1'b1, r, f, lat, pok);
      check(r == -128'sd3, "R1 after reset", r, -128'sd3);

      $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
      $finish;
   end

endmodule